// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block steps through four sequencer states on debug events and fires a trace-session trigger when it reaches the last state. Its inputs are single-cycle match pulses from a set of address/data comparators, two other hardware sources (an external instruction-tag request and a coprocessor software breakpoint request), and a small register write port. Software uses that port to configure each state and to arm or force the sequencer.

Each of the first three states has its own configuration slot. The slot picks one source and says whether a match on it is a *force* trigger or a *tagged* trigger. A force trigger waits for the next instruction-boundary strobe. A tagged trigger waits for the strobe that says the tagged instruction is about to execute. The match is held in a pending flag until its strobe arrives, and the sequencer then moves on one state.

On entry to the final state, the block sends a one-cycle pulse to the trace controller and disarms itself. It can also send breakpoint requests in the same cycle: a CPU request that either halts into debug mode or runs a software interrupt, and a coprocessor request.

The states are `SEQ_S1` (code 0), `SEQ_S2` (1), `SEQ_S3` (2) and `SEQ_FINAL` (3). The transitions are:
- ARM: a control write with the arm bit set, from any state to `SEQ_S1`.
- ADVANCE: a pending trigger is released, moving `SEQ_S1`→`SEQ_S2`, `SEQ_S2`→`SEQ_S3` or `SEQ_S3`→`SEQ_FINAL`.
- FORCE: a control write with the trigger bit set, from any state to `SEQ_FINAL`.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset the state is `SEQ_S1` (code 0) and the sequencer is disarmed. `trace_trig`, `brk_halt`, `brk_swi` and `brk_cop` are all low. Every configuration slot selects no source.
- R2: Address 0 is the control register. Bit 0 is arm, bit 1 is trigger, bit 2 is CPU breakpoint enable, bit 3 selects software interrupt (1) or halt (0), and bit 4 is coprocessor breakpoint enable. A control write with bit 0 = 1 and bit 1 = 0 gives `seq_state` = 0 and `seq_armed` = 1 after that edge, and drops any pending trigger. A control write with both bits 0 and 1 clear disarms the sequencer and leaves the state unchanged.
- R3: Addresses 1 to 3 configure states `SEQ_S1` to `SEQ_S3`. In a slot with bit 3 = 0 (force), a pulse on the selected source while armed sets a pending flag. The first boundary strobe in a later cycle advances the state by one at that edge. A boundary strobe in the same cycle as the match does not count.
- R4: In a slot with bit 3 = 1 (tagged), the pending match advances the state only on the tag-reached strobe. Boundary strobes leave it pending.
- R5: Slot bits [2:0] pick the source. Codes 0 to 3 are comparators 0 to 3, code 4 is the external tag request, code 5 is the coprocessor breakpoint request, and codes 6 and 7 pick nothing. Pulses on sources that are not selected have no effect on the state.
- R6: On each entry into `SEQ_FINAL`, `trace_trig` is high for exactly the first cycle in that state, and `seq_armed` is low in that cycle.
- R7: A control write with bit 1 = 1 moves the sequencer to `SEQ_FINAL` at that edge from any state, even if it is not armed, and fires the R6 entry. It takes priority over the arm bit of the same write and over a pending trigger released in the same cycle, so the result is a single entry.
- R8: In the cycle of `trace_trig`, `brk_halt` is high if the CPU enable is set and the select bit is 0, and `brk_swi` is high if the CPU enable is set and the select bit is 1. `brk_cop` is high if the coprocessor enable is set. The enables are the control values in force after that edge, including those written by the same trigger write. No breakpoint output is ever high without `trace_trig`.
- R9: While disarmed, no source or strobe changes the state.
- R10: While a trigger is pending, further matches are ignored, and one release advances the state by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1–3 state slots |
| reg_wdata | input | 5 | Write data |
| cmp_hit | input | 4 | Per-comparator match pulses |
| ext_tag_req | input | 1 | External instruction-tag request pulse |
| cop_brk_req | input | 1 | Coprocessor software breakpoint request pulse |
| boundary_stb | input | 1 | Instruction-boundary strobe |
| tag_hit_stb | input | 1 | Tagged instruction about to execute |
| seq_state | output | 2 | Current state code |
| seq_armed | output | 1 | Sequencer armed |
| trace_trig | output | 1 | Trace-session trigger pulse |
| brk_halt | output | 1 | CPU breakpoint request, halt into debug mode |
| brk_swi | output | 1 | CPU breakpoint request, software interrupt |
| brk_cop | output | 1 | Coprocessor breakpoint request |

## Verification
The bench provokes a forced trigger write (R7) in the same cycle as a tag-reached strobe that would release a pending tagged trigger out of `SEQ_S2`. That write also sets the arm bit. The judgment is that exactly one `trace_trig` appears: the scoreboard holds one queued item for that entry, and any second pulse pops an empty queue and counts as a mismatch. The state, armed flag and breakpoint outputs after that edge must match the newly written control value.

// File: rtl/dbg_trig_seq_pkg.sv
package dbg_trig_seq_pkg;

    localparam int SEQ_NSTATE = 4;
    localparam int ADDR_W     = $clog2(SEQ_NSTATE);
    localparam int CTL_W      = 5;

    // control register bit positions
    localparam int CTL_ARM  = 0;
    localparam int CTL_TRIG = 1;
    localparam int CTL_CPU  = 2;
    localparam int CTL_SWI  = 3;
    localparam int CTL_COP  = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTL = '0;

    typedef enum logic [ADDR_W-1:0] {
        SEQ_S1    = 2'd0,
        SEQ_S2    = 2'd1,
        SEQ_S3    = 2'd2,
        SEQ_FINAL = 2'd3
    } seq_state_e;

    typedef enum logic {
        PEND_FORCE = 1'b0,
        PEND_TAG   = 1'b1
    } pend_kind_e;

endpackage

// File: rtl/dbg_trig_seq_regs.sv
module dbg_trig_seq_regs
    import dbg_trig_seq_pkg::*;
#(
    parameter int SRC_W = 3,
    parameter int REG_W = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_we,
    input  logic [ADDR_W-1:0]                   reg_addr,
    input  logic [REG_W-1:0]                    reg_wdata,
    output logic [SEQ_NSTATE-1:0][SRC_W-1:0]    slot_src,
    output logic [SEQ_NSTATE-1:0]               slot_tagged,
    output logic                                cpu_en_nx,
    output logic                                swi_nx,
    output logic                                cop_en_nx,
    output logic                                arm_wr,
    output logic                                disarm_wr,
    output logic                                trig_wr
);

    logic ctl_wr;
    logic cpu_en_q, swi_q, cop_en_q;

    assign ctl_wr    = reg_we && (reg_addr == ADDR_CTL);
    assign trig_wr   = ctl_wr && reg_wdata[CTL_TRIG];
    assign arm_wr    = ctl_wr && reg_wdata[CTL_ARM];
    assign disarm_wr = ctl_wr && !reg_wdata[CTL_ARM];

    // values in force after this edge (a write applies immediately)
    assign cpu_en_nx = ctl_wr ? reg_wdata[CTL_CPU] : cpu_en_q;
    assign swi_nx    = ctl_wr ? reg_wdata[CTL_SWI] : swi_q;
    assign cop_en_nx = ctl_wr ? reg_wdata[CTL_COP] : cop_en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_en_q <= 1'b0;
            swi_q    <= 1'b0;
            cop_en_q <= 1'b0;
        end else begin
            cpu_en_q <= cpu_en_nx;
            swi_q    <= swi_nx;
            cop_en_q <= cop_en_nx;
        end
    end

    for (genvar g = 0; g < SEQ_NSTATE; g++) begin : g_slot
        if (g < SEQ_NSTATE - 1) begin : g_cfg
            logic [SRC_W-1:0] src_q;
            logic             tag_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    src_q <= '1;
                    tag_q <= 1'b0;
                end else if (reg_we && reg_addr == ADDR_W'(g + 1)) begin
                    src_q <= reg_wdata[SRC_W-1:0];
                    tag_q <= reg_wdata[SRC_W];
                end
            end
            assign slot_src[g]    = src_q;
            assign slot_tagged[g] = tag_q;
        end else begin : g_final
            // final state has no transition: selects nothing
            assign slot_src[g]    = '1;
            assign slot_tagged[g] = 1'b0;
        end
    end

endmodule

// File: rtl/dbg_trig_seq_srcsel.sv
module dbg_trig_seq_srcsel #(
    parameter int NUM_CMP = 4,
    parameter int SRC_W   = 3
) (
    input  logic [NUM_CMP-1:0] cmp_hit,
    input  logic               ext_tag_req,
    input  logic               cop_brk_req,
    input  logic [SRC_W-1:0]   sel,
    output logic               hit
);

    localparam int NPAD = 1 << SRC_W;

    logic [NPAD-1:0] padded;

    // codes: 0..NUM_CMP-1 comparators, NUM_CMP external tag,
    // NUM_CMP+1 coprocessor request, the rest select nothing
    assign padded = NPAD'({cop_brk_req, ext_tag_req, cmp_hit});
    assign hit    = padded[sel];

endmodule

// File: rtl/dbg_trig_seq_pend.sv
module dbg_trig_seq_pend
    import dbg_trig_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cap,
    input  logic cap_tagged,
    input  logic boundary_stb,
    input  logic tag_hit_stb,
    output logic busy,
    output logic fire
);

    pend_kind_e kind_q;
    logic       busy_q;

    assign busy = busy_q;
    assign fire = busy_q && ((kind_q == PEND_TAG) ? tag_hit_stb : boundary_stb);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            kind_q <= PEND_FORCE;
        end else if (clr || fire) begin
            busy_q <= 1'b0;
        end else if (cap && !busy_q) begin
            busy_q <= 1'b1;
            kind_q <= cap_tagged ? PEND_TAG : PEND_FORCE;
        end
    end

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dbg_trig_seq_pkg::*;
#(
    parameter int NUM_CMP = 4,
    localparam int SRC_W  = $clog2(NUM_CMP + 3),
    localparam int REG_W  = (SRC_W + 1 > CTL_W) ? SRC_W + 1 : CTL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic [NUM_CMP-1:0] cmp_hit,
    input  logic               ext_tag_req,
    input  logic               cop_brk_req,
    input  logic               boundary_stb,
    input  logic               tag_hit_stb,
    output logic [ADDR_W-1:0]  seq_state,
    output logic               seq_armed,
    output logic               trace_trig,
    output logic               brk_halt,
    output logic               brk_swi,
    output logic               brk_cop
);

    seq_state_e state_q, state_d;
    logic       armed_q, armed_d;
    logic       go_final;

    logic [SEQ_NSTATE-1:0][SRC_W-1:0] slot_src;
    logic [SEQ_NSTATE-1:0]            slot_tagged;
    logic cpu_en_nx, swi_nx, cop_en_nx;
    logic arm_wr, disarm_wr, trig_wr;
    logic [ADDR_W-1:0] st_idx;
    logic active, src_hit, pend_busy, pend_fire, advance;

    dbg_trig_seq_regs #(.SRC_W(SRC_W), .REG_W(REG_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .slot_src    (slot_src),
        .slot_tagged (slot_tagged),
        .cpu_en_nx   (cpu_en_nx),
        .swi_nx      (swi_nx),
        .cop_en_nx   (cop_en_nx),
        .arm_wr      (arm_wr),
        .disarm_wr   (disarm_wr),
        .trig_wr     (trig_wr)
    );

    assign st_idx = state_q;
    assign active = armed_q && (state_q != SEQ_FINAL);

    dbg_trig_seq_srcsel #(.NUM_CMP(NUM_CMP), .SRC_W(SRC_W)) srcsel_i (
        .cmp_hit     (cmp_hit),
        .ext_tag_req (ext_tag_req),
        .cop_brk_req (cop_brk_req),
        .sel         (slot_src[st_idx]),
        .hit         (src_hit)
    );

    dbg_trig_seq_pend pend_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (arm_wr || disarm_wr || trig_wr),
        .cap          (active && src_hit),
        .cap_tagged   (slot_tagged[st_idx]),
        .boundary_stb (boundary_stb),
        .tag_hit_stb  (tag_hit_stb),
        .busy         (pend_busy),
        .fire         (pend_fire)
    );

    assign advance = active && pend_busy && pend_fire;

    // next-state logic: FORCE > ARM > ADVANCE
    always_comb begin
        state_d  = state_q;
        armed_d  = armed_q;
        go_final = 1'b0;
        if (trig_wr) begin
            state_d  = SEQ_FINAL;
            go_final = 1'b1;
        end else if (arm_wr) begin
            state_d = SEQ_S1;
            armed_d = 1'b1;
        end else if (disarm_wr) begin
            armed_d = 1'b0;
        end else if (advance) begin
            unique case (state_q)
                SEQ_S1:    state_d = SEQ_S2;
                SEQ_S2:    state_d = SEQ_S3;
                SEQ_S3: begin
                    state_d  = SEQ_FINAL;
                    go_final = 1'b1;
                end
                SEQ_FINAL: state_d = SEQ_FINAL;
            endcase
        end
        if (go_final) armed_d = 1'b0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_S1;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_trig <= 1'b0;
            brk_halt   <= 1'b0;
            brk_swi    <= 1'b0;
            brk_cop    <= 1'b0;
        end else begin
            trace_trig <= go_final;
            brk_halt   <= go_final && cpu_en_nx && !swi_nx;
            brk_swi    <= go_final && cpu_en_nx && swi_nx;
            brk_cop    <= go_final && cop_en_nx;
        end
    end

    assign seq_state = state_q;
    assign seq_armed = armed_q;

endmodule

// File: rtl/dbg_trig_seq_chk.sv
module dbg_trig_seq_chk
    import dbg_trig_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [1:0]        ctl_lo,
    input logic [ADDR_W-1:0] seq_state,
    input logic              seq_armed,
    input logic              trace_trig,
    input logic              brk_halt,
    input logic              brk_swi,
    input logic              brk_cop
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r2_arm_to_first: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_CTL && ctl_lo[CTL_ARM] && !ctl_lo[CTL_TRIG])
        |=> (seq_state == 2'd0 && seq_armed));

    a_r7_force_final: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_CTL && ctl_lo[CTL_TRIG])
        |=> (seq_state == 2'd3 && trace_trig && !seq_armed));

    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (seq_state != $past(seq_state) && !$past(reg_we))
        |-> (seq_state == $past(seq_state) + 2'd1));

    a_r9_needs_arm: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (seq_state != $past(seq_state) && !$past(reg_we)) |-> $past(seq_armed));

    a_r6_trig_in_final: assert property (@(posedge clk) disable iff (!rst_n)
        trace_trig |-> (seq_state == 2'd3 && !seq_armed));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_trig && !reg_we) |=> !trace_trig);

    a_r8_brk_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_halt || brk_swi || brk_cop) |-> trace_trig);

    a_r8_cpu_kind_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_halt && brk_swi));

endmodule

bind dbg_trig_seq dbg_trig_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .ctl_lo     (reg_wdata[1:0]),
    .seq_state  (seq_state),
    .seq_armed  (seq_armed),
    .trace_trig (trace_trig),
    .brk_halt   (brk_halt),
    .brk_swi    (brk_swi),
    .brk_cop    (brk_cop)
);

// File: tb/dbg_trig_seq_tb_top.sv
`timescale 1ns/1ps
module dbg_trig_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [4:0] reg_wdata = '0;
    logic [3:0] cmp_hit = '0;
    logic       ext_tag_req = 1'b0, cop_brk_req = 1'b0;
    logic       boundary_stb = 1'b0, tag_hit_stb = 1'b0;
    logic [1:0] seq_state;
    logic       seq_armed, trace_trig, brk_halt, brk_swi, brk_cop;

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] exp_q[$];   // {halt, swi, cop} per expected trigger

    always #2.5 clk = ~clk;

    dbg_trig_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cmp_hit(cmp_hit), .ext_tag_req(ext_tag_req),
        .cop_brk_req(cop_brk_req), .boundary_stb(boundary_stb),
        .tag_hit_stb(tag_hit_stb), .seq_state(seq_state), .seq_armed(seq_armed),
        .trace_trig(trace_trig), .brk_halt(brk_halt), .brk_swi(brk_swi),
        .brk_cop(brk_cop)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // one cycle of stimulus, returns at the following negedge
    task automatic step(input logic we, input logic [1:0] a, input logic [4:0] d,
                        input logic [3:0] cmp, input logic ext, input logic cop,
                        input logic bnd, input logic tag);
        reg_we = we; reg_addr = a; reg_wdata = d; cmp_hit = cmp;
        ext_tag_req = ext; cop_brk_req = cop; boundary_stb = bnd; tag_hit_stb = tag;
        @(negedge clk);
        reg_we = 0; reg_addr = '0; reg_wdata = '0; cmp_hit = '0;
        ext_tag_req = 0; cop_brk_req = 0; boundary_stb = 0; tag_hit_stb = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [4:0] d);
        step(1'b1, a, d, 4'h0, 0, 0, 0, 0);
    endtask

    // monitor: pops one expected item per trace trigger pulse
    always @(negedge clk) begin
        if (rst_n && trace_trig) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R6 unexpected trigger: actual 1 expected 0");
            end else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                if ({brk_halt, brk_swi, brk_cop} != e) begin
                    n_bad++;
                    $display("FAIL R8 breakpoint set: actual %b expected %b",
                             {brk_halt, brk_swi, brk_cop}, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1", "state", seq_state, 0);
        chk("R1", "armed", seq_armed, 0);
        chk("R1", "outputs", {trace_trig, brk_halt, brk_swi, brk_cop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R5: unconfigured slots select nothing even when armed
        wr(2'd0, 5'h01);
        step(0, 0, 0, 4'hF, 1, 1, 0, 0);
        step(0, 0, 0, 4'h0, 0, 0, 1, 1);
        chk("R1", "unconfigured slot idle", seq_state, 0);

        // configure: S1 cmp0 force, S2 ext tag tagged, S3 cop force
        wr(2'd1, 5'h00);
        wr(2'd2, 5'h0C);
        wr(2'd3, 5'h05);
        wr(2'd0, 5'h05);               // arm, CPU halt
        chk("R2", "state after arm", seq_state, 0);
        chk("R2", "armed after arm", seq_armed, 1);

        // R5: non-selected comparator ignored
        step(0, 0, 0, 4'h2, 1, 1, 0, 0);
        step(0, 0, 0, 4'h0, 0, 0, 1, 0);
        chk("R5", "non-selected source", seq_state, 0);
        // R3: boundary in the match cycle does not count
        step(0, 0, 0, 4'h1, 0, 0, 1, 0);
        chk("R3", "same-cycle boundary", seq_state, 0);
        step(0, 0, 0, 4'h0, 0, 0, 1, 0);
        chk("R3", "later boundary advances", seq_state, 1);

        // R4: tagged slot waits for tag strobe
        step(0, 0, 0, 4'h0, 1, 0, 0, 0);
        step(0, 0, 0, 4'h0, 0, 0, 1, 0);
        chk("R4", "boundary ignored for tag", seq_state, 1);
        step(0, 0, 0, 4'h0, 0, 0, 0, 1);
        chk("R4", "tag strobe advances", seq_state, 2);

        // R6/R8: final entry from S3 with halt request
        step(0, 0, 0, 4'h0, 0, 1, 0, 0);
        exp_q.push_back(3'b100);
        step(0, 0, 0, 4'h0, 0, 0, 1, 0);
        chk("R6", "final state", seq_state, 3);
        chk("R6", "trigger pulse", trace_trig, 1);
        chk("R6", "disarmed in final", seq_armed, 0);
        chk("R8", "halt request", brk_halt, 1);
        step(0, 0, 0, 4'h0, 0, 0, 1, 1);
        chk("R6", "pulse lasts one cycle", trace_trig, 0);

        // R9: disarmed sequencer does not move
        wr(2'd0, 5'h05);
        wr(2'd0, 5'h04);
        chk("R2", "disarm write", seq_armed, 0);
        step(0, 0, 0, 4'h1, 0, 0, 0, 0);
        step(0, 0, 0, 4'h0, 0, 0, 1, 0);
        chk("R9", "no advance while disarmed", seq_state, 0);

        // R10: second match while pending ignored, single advance
        wr(2'd0, 5'h1D);               // arm, CPU swi, coprocessor
        step(0, 0, 0, 4'h1, 0, 0, 0, 0);
        step(0, 0, 0, 4'h1, 0, 0, 0, 0);
        step(0, 0, 0, 4'h0, 0, 0, 1, 0);
        chk("R10", "first release", seq_state, 1);
        step(0, 0, 0, 4'h0, 0, 0, 1, 0);
        chk("R10", "no second advance", seq_state, 1);

        // R7: trigger write coinciding with tag release and arm bit
        step(0, 0, 0, 4'h0, 1, 0, 0, 0);
        exp_q.push_back(3'b011);
        step(1, 2'd0, 5'h1F, 4'h0, 0, 0, 0, 1);
        chk("R7", "forced final", seq_state, 3);
        chk("R7", "forced disarm", seq_armed, 0);
        chk("R8", "swi request", brk_swi, 1);
        @(negedge clk);
        chk("R7", "single entry", trace_trig, 0);

        // R7: forced trigger from final while disarmed, coprocessor only
        exp_q.push_back(3'b001);
        wr(2'd0, 5'h12);
        chk("R7", "re-trigger from final", trace_trig, 1);
        chk("R8", "coprocessor request", brk_cop, 1);

        // R5: code 6 selects nothing
        wr(2'd1, 5'h06);
        wr(2'd0, 5'h01);
        step(0, 0, 0, 4'hF, 1, 1, 0, 0);
        step(0, 0, 0, 4'h0, 0, 0, 1, 1);
        step(0, 0, 0, 4'h0, 0, 0, 1, 1);
        chk("R5", "empty source code", seq_state, 0);

        chk("R6", "scoreboard drained", exp_q.size(), 0);
        summary();
    end

endmodule